// File: doc/BRIEF.md
# SPI Interrupt Flag Controller

This block sits between an SPI shift engine, in master or slave role, and a simple register bus. It holds one transmit data word and a two-stage receive store. It tracks three interrupt causes: transmit buffer empty, receive buffer full and receive overrun. Each cause has its own enable bit and its own status flag. Software clears a flag by writing 1 to it. A single registered interrupt request goes to an external interrupt controller.

The shift engine is seen only through strobes. `txLoad` means the engine has taken the buffered transmit word into its shift register. `rxDone` together with `rxWord` delivers a completed received word. When a word completes while an unread word is still held, the block keeps the new word in a second stage and raises the overrun flag. Recovery then has a fixed order: software clears the error flag, and only after that do reads of the receive register drain the two stored words.

Top module: `spi_irq_flag_ctrl`

## Requirements
- R1: After reset (synchronous, `rstN` low), all enable bits, all status flags and `irqOut` are 0, `txValid` is 0 and the receive store is empty.
- R2: `irqOut` equals the OR over the three causes of (flag AND enable), registered one clock after the flags. A flag still sets while its enable is 0. Bit positions in both the enable and the status register: bit 0 is transmit empty, bit 1 is receive full, bit 2 is receive error.
- R3: A `txLoad` pulse while a transmit word is buffered sets the transmit-empty flag and drops `txValid`. A write to the transmit data register stores the word, raises `txValid` and clears the transmit-empty flag, and the write wins over a `txLoad` in the same cycle. A `txLoad` with no buffered word is ignored.
- R4: An `rxDone` pulse sets the receive-full flag. The flag drops when a read removes the last stored word.
- R5: An `rxDone` that arrives while an unread word remains after any same-cycle read sets the error flag, and the new word is kept in a second stage. A word that arrives while both stages are full replaces the newest stored word.
- R6: Writing 1 to a status bit clears it and writing 0 has no effect. A set event in the same cycle as a write-1 clear leaves the flag set.
- R7: While the error flag is 1, a read of the receive data register returns the oldest word without removing it.
- R8: Reads of the receive data register return stored words oldest first and remove each one. A read of an empty store returns 0.
- R9: Register addresses: 0 is enable (read/write), 1 is status (read, write 1 to clear), 2 is transmit data (read/write), 3 is receive data (read only). Read data is valid in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 for a write access, 0 for a read access |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the address |
| txLoad | input | 1 | Engine takes the buffered transmit word |
| txWord | output | 8 | Buffered transmit word |
| txValid | output | 1 | A transmit word is waiting |
| rxDone | input | 1 | Engine delivers a completed received word |
| rxWord | input | 8 | Received word, valid with rxDone |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The sharpest collisions are a bus access and an engine strobe in the same clock. The bench drives these cases in one cycle: a receive-data read with an `rxDone` while one word is stored, a status write-1 clear with an `rxDone` on an empty store, and a transmit-data write with a `txLoad`. It then judges the result through the status register and the order of the words read back. In the first case no overrun may be flagged and the new word must follow the old one. In the second the receive-full flag must survive. In the third the newly written word must stay buffered with the transmit-empty flag low.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int CAUSE_N = 3;
  localparam int C_TXE = 0;
  localparam int C_RXF = 1;
  localparam int C_ERR = 2;
  localparam int RX_DEPTH = 2;

  localparam logic [1:0] A_ENABLE = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_TXDATA = 2'd2;
  localparam logic [1:0] A_RXDATA = 2'd3;

  typedef struct packed {
    logic txWrite;
    logic txTake;
    logic rxPush;
    logic rxPop;
  } dpStrobe_t;
endpackage

// File: rtl/spi_irq_data.sv
module spi_irq_data
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH = RX_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] txWord,
  output logic              txValid,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  rxCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [CNT_W-1:0]  afterPop;
  logic [CNT_W-1:0]  pushIdx;
  logic [CNT_W-1:0]  countNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord  <= '0;
      txValid <= 1'b0;
    end else if (stb.txWrite) begin
      txWord  <= wrData;
      txValid <= 1'b1;
    end else if (stb.txTake) begin
      txValid <= 1'b0;
    end
  end

  always_comb begin
    afterPop = rxCount - CNT_W'(stb.rxPop);
    pushIdx  = (afterPop == FULL) ? FULL - 1'b1 : afterPop;
    if (stb.rxPush)
      countNext = (afterPop == FULL) ? FULL : afterPop + 1'b1;
    else
      countNext = afterPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxCount <= '0;
    else       rxCount <= countNext;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    if (i == DEPTH - 1) begin : gLast
      always_ff @(posedge clk) begin
        if (!rstN) slotQ[i] <= '0;
        else if (stb.rxPush && pushIdx == CNT_W'(i)) slotQ[i] <= rxWord;
      end
    end else begin : gMid
      always_ff @(posedge clk) begin
        if (!rstN) slotQ[i] <= '0;
        else if (stb.rxPush && pushIdx == CNT_W'(i)) slotQ[i] <= rxWord;
        else if (stb.rxPop) slotQ[i] <= slotQ[i+1];
      end
    end
  end

  assign rxHead = (rxCount == '0) ? '0 : slotQ[0];
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DEPTH = RX_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CAUSE_N-1:0] wrBits,
  input  logic               txLoad,
  input  logic               rxDone,
  input  logic               txValid,
  input  logic [CNT_W-1:0]   rxCount,
  output dpStrobe_t          stb,
  output logic [CAUSE_N-1:0] enQ,
  output logic [CAUSE_N-1:0] flagQ,
  output logic               irqOut
);
  logic               wrStb, rdStb;
  logic [CNT_W-1:0]   afterPop;
  logic               overrun, drained;
  logic [CAUSE_N-1:0] setVec, clrVec, w1cVec;

  always_comb begin
    wrStb       = busSel && busWr;
    rdStb       = busSel && !busWr;
    stb.txWrite = wrStb && busAddr == ADDR_W'(A_TXDATA);
    stb.txTake  = txLoad && txValid;
    stb.rxPush  = rxDone;
    stb.rxPop   = rdStb && busAddr == ADDR_W'(A_RXDATA)
                  && rxCount != '0 && !flagQ[C_ERR];
    afterPop    = rxCount - CNT_W'(stb.rxPop);
    overrun     = rxDone && afterPop != '0;
    drained     = stb.rxPop && rxCount == CNT_W'(1) && !rxDone;
    w1cVec      = (wrStb && busAddr == ADDR_W'(A_STATUS)) ? wrBits : '0;

    setVec        = '0;
    setVec[C_TXE] = stb.txTake && !stb.txWrite;
    setVec[C_RXF] = rxDone;
    setVec[C_ERR] = overrun;

    clrVec        = w1cVec;
    clrVec[C_TXE] = w1cVec[C_TXE] || stb.txWrite;
    clrVec[C_RXF] = w1cVec[C_RXF] || drained;
  end

  always_ff @(posedge clk) begin
    if (!rstN) enQ <= '0;
    else if (wrStb && busAddr == ADDR_W'(A_ENABLE)) enQ <= wrBits;
  end

  for (genvar c = 0; c < CAUSE_N; c++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[c] <= 1'b0;
      else       flagQ[c] <= setVec[c] || (flagQ[c] && !clrVec[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(flagQ & enQ);
  end
endmodule

// File: rtl/spi_irq_flag_ctrl.sv
module spi_irq_flag_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int DEPTH = RX_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              txLoad,
  output logic [DATA_W-1:0] txWord,
  output logic              txValid,
  input  logic              rxDone,
  input  logic [DATA_W-1:0] rxWord,
  output logic              irqOut
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dpStrobe_t          stb;
  logic [CAUSE_N-1:0] enQ, flagQ;
  logic [CNT_W-1:0]   rxCount;
  logic [DATA_W-1:0]  rxHead;

  spi_irq_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .wrBits(busWdata[CAUSE_N-1:0]),
    .txLoad(txLoad), .rxDone(rxDone), .txValid(txValid),
    .rxCount(rxCount), .stb(stb), .enQ(enQ), .flagQ(flagQ),
    .irqOut(irqOut)
  );

  spi_irq_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .rxWord(rxWord), .txWord(txWord), .txValid(txValid),
    .rxHead(rxHead), .rxCount(rxCount)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(A_ENABLE): busRdata[CAUSE_N-1:0] = enQ;
      ADDR_W'(A_STATUS): busRdata[CAUSE_N-1:0] = flagQ;
      ADDR_W'(A_TXDATA): busRdata = txWord;
      ADDR_W'(A_RXDATA): busRdata = rxHead;
      default:           busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               wrErrBit,
  input logic               txLoad,
  input logic               txValid,
  input logic               rxDone,
  input logic               irqOut,
  input logic [CAUSE_N-1:0] enQ,
  input logic [CAUSE_N-1:0] flagQ,
  input logic [CNT_W-1:0]   rxCount
);
  // R2: nothing enabled means no request one clock later
  a_r2_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |=> !irqOut);

  // R3: a take of a buffered word flags transmit empty unless a write collides
  a_r3_take_sets_empty: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && txValid && !(busSel && busWr && busAddr == ADDR_W'(A_TXDATA)))
    |=> flagQ[C_TXE]);

  // R4: every delivered word flags receive full
  a_r4_push_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> flagQ[C_RXF]);

  // R5: a word arriving on a full store is an overrun
  a_r5_full_store_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxCount == CNT_W'(RX_DEPTH)) |=> flagQ[C_ERR]);

  // R5: the store never exceeds its depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(RX_DEPTH));

  // R6: write-1 clears the error flag when no new word arrives
  a_r6_w1c_clears_err: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(A_STATUS) && wrErrBit && !rxDone)
    |=> !flagQ[C_ERR]);

  // R7: reads during a pending error leave the store unchanged
  a_r7_locked_read: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[C_ERR] && busSel && !busWr && busAddr == ADDR_W'(A_RXDATA) && !rxDone)
    |=> $stable(rxCount));
endmodule

bind spi_irq_flag_ctrl spi_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .wrErrBit(busWdata[spi_irq_pkg::C_ERR]), .txLoad(txLoad), .txValid(txValid),
  .rxDone(rxDone), .irqOut(irqOut), .enQ(enQ), .flagQ(flagQ), .rxCount(rxCount)
);

// File: tb/spi_irq_flag_ctrl_tb_top.sv
module spi_irq_flag_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, txLoad = 1'b0, rxDone = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0, rxWord = '0;
  logic [7:0] busRdata, txWord;
  logic       txValid, irqOut;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  spi_irq_flag_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txLoad(txLoad), .txWord(txWord),
    .txValid(txValid), .rxDone(rxDone), .rxWord(rxWord), .irqOut(irqOut)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && busSel && !busWr) begin
      if (expQ.size() == 0) check(8'hEE, 8'h00, "unexpected read");
      else check(busRdata, expQ.pop_front(), tagQ.pop_front());
    end
  end

  // one bus/engine cycle; starts and ends just after a rising edge
  task automatic cyc(input logic sel, input logic wr, input logic [1:0] a,
                     input logic [7:0] d, input logic rd, input logic [7:0] rw,
                     input logic tl, input logic [7:0] exp, input string tag);
    busSel = sel; busWr = wr; busAddr = a; busWdata = d;
    rxDone = rd; rxWord = rw; txLoad = tl;
    if (sel && !wr) begin expQ.push_back(exp); tagQ.push_back(tag); end
    @(posedge clk); #1;
    busSel = 0; busWr = 0; rxDone = 0; txLoad = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    cyc(1, 0, a, 8'h00, 0, 8'h00, 0, exp, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0, 8'h00, 0, 8'h00, "");
  endtask
  task automatic rxPulse(input logic [7:0] w);
    cyc(0, 0, 2'd0, 8'h00, 1, w, 0, 8'h00, "");
  endtask
  task automatic txPulse();
    cyc(0, 0, 2'd0, 8'h00, 0, 8'h00, 1, 8'h00, "");
  endtask
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChk++; nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check({7'b0, irqOut}, 8'h00, "R1 irq");
    check({7'b0, txValid}, 8'h00, "R1 txValid");
    rd(2'd0, 8'h00, "R1 enable");
    rd(2'd1, 8'h00, "R1 status");
    rd(2'd3, 8'h00, "R8 empty read");

    // R2 flag sets while disabled, no request
    rxPulse(8'hA5);
    tick();
    check({7'b0, irqOut}, 8'h00, "R2 disabled irq");
    rd(2'd1, 8'h02, "R4 full flag");
    rd(2'd3, 8'hA5, "R8 first word");
    rd(2'd1, 8'h00, "R4 flag drops");

    // R2 enabled request arrives one clock after the flag
    wr(2'd0, 8'h02);
    rd(2'd0, 8'h02, "R9 enable readback");
    rxPulse(8'h3C);
    check({7'b0, irqOut}, 8'h00, "R2 irq registered");
    tick();
    check({7'b0, irqOut}, 8'h01, "R2 irq on");
    rd(2'd3, 8'h3C, "R8 word");
    tick();
    check({7'b0, irqOut}, 8'h00, "R2 irq off");

    // R3 transmit path
    wr(2'd2, 8'h5A);
    check({7'b0, txValid}, 8'h01, "R3 txValid");
    check(txWord, 8'h5A, "R3 txWord");
    rd(2'd2, 8'h5A, "R9 tx readback");
    txPulse();
    check({7'b0, txValid}, 8'h00, "R3 taken");
    rd(2'd1, 8'h01, "R3 empty flag");
    wr(2'd2, 8'h77);
    rd(2'd1, 8'h00, "R3 write clears");
    cyc(1, 1, 2'd2, 8'h88, 0, 8'h00, 1, 8'h00, "");
    check(txWord, 8'h88, "R3 collide word");
    check({7'b0, txValid}, 8'h01, "R3 collide valid");
    rd(2'd1, 8'h00, "R3 write beats take");
    txPulse();
    rd(2'd1, 8'h01, "R3 second take");
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h00, "R6 w1c tx");
    txPulse();
    rd(2'd1, 8'h00, "R3 empty take ignored");

    // R6 write zero has no effect
    rxPulse(8'h11);
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h02, "R6 zero write");
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h00, "R6 w1c rx");
    rd(2'd3, 8'h11, "R8 word after clear");

    // R5 overrun and R7 recovery order
    rxPulse(8'h21);
    rxPulse(8'h22);
    rd(2'd1, 8'h06, "R5 overrun flag");
    rd(2'd3, 8'h21, "R7 locked read 1");
    rd(2'd3, 8'h21, "R7 locked read 2");
    wr(2'd1, 8'h04);
    rd(2'd1, 8'h02, "R6 err cleared");
    rd(2'd3, 8'h21, "R5 oldest kept");
    rd(2'd3, 8'h22, "R5 second stage");
    rd(2'd3, 8'h00, "R8 empty again");
    rd(2'd1, 8'h00, "R4 drained");

    // R5 arrival on a full store replaces the newest
    rxPulse(8'h31);
    rxPulse(8'h32);
    rxPulse(8'h33);
    wr(2'd1, 8'h04);
    rd(2'd3, 8'h31, "R5 oldest survives");
    rd(2'd3, 8'h33, "R5 newest replaced");

    // R6 set beats clear in the same cycle
    cyc(1, 1, 2'd1, 8'h02, 1, 8'h44, 0, 8'h00, "");
    rd(2'd1, 8'h02, "R6 set wins");
    rd(2'd3, 8'h44, "R8 collided word");

    // R5/R8 read and arrival in the same cycle: no overrun
    rxPulse(8'h51);
    cyc(1, 0, 2'd3, 8'h00, 1, 8'h52, 0, 8'h51, "R8 read with arrival");
    rd(2'd1, 8'h02, "R5 no overrun on pop");
    rd(2'd3, 8'h52, "R8 order kept");

    tick();
    check(8'(expQ.size()), 8'h00, "R9 all reads seen");
    finishRun();
  end
endmodule